// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog that counts coarse ticks derived from the bus clock. Each tick lasts 2^TICK_LOG2 bus cycles. A free-running prescaler produces the ticks, and it restarts when the watchdog is started and on every accepted ping.

Once enabled, the watchdog runs two timeout phases back to back:

- **Phase 1.** Software keeps the system alive by pinging. Each ping starts phase 1 over from zero.
- **Phase 2.** A grace period that pings cannot shorten or cancel. Only turning the watchdog off stops the reset.

The end of phase 1 latches a pretimeout interrupt. The end of phase 2 latches an expiry interrupt and, in the same cycle, sends a one-cycle pulse on one of three reset outputs. The reset-scope field picks which output. After that pulse the watchdog turns itself off.

Software uses a three-word register port: word 0 is control, word 1 holds the phase lengths, word 2 is the ping register. With the default TICK_LOG2 of 28 and a 200 MHz clock, 32 ticks last roughly 43 seconds.

Top module: `wdog_twophase`

## Requirements
- R1: After a control write that sets the enable bit (bit 0) while the watchdog is off (edge E0), phase 1 lasts L1 ticks. At edge E0+L1*2^TICK_LOG2, irq_pre goes high and phase 2 begins. Phase 2 lasts L2 ticks, and the reset pulse follows edge E0+(L1+L2)*2^TICK_LOG2.
- R2: Word 1 holds the phase lengths as tick count minus one. Bits [4:0] are phase 1 and bits [12:8] are phase 2, so each length runs from 1 to 32 ticks. Word 1 reads back as written and comes out of reset as 0x1F1F.
- R3: Any write to word 2 during phase 1 restarts both the phase 1 count and the prescaler. Phase 1 then ends L1 ticks after that write's edge.
- R4: A write to word 2 during phase 2 has no effect. The reset still comes at the originally scheduled edge.
- R5: A control write with bit 0 clear stops the watchdog in either phase. No later interrupt or reset occurs, and control bit 0 then reads 0.
- R6: irq_expire rises in the same cycle as the reset pulse. Both irq_pre and irq_expire stay high until cleared.
- R7: A control write with bit 8 set clears irq_pre, and one with bit 9 set clears irq_expire. Each flag is visible at control bits 8 and 9.
- R8: Control bits [2:1] select the reset scope: 0 = whole chip (rst_chip), 1 = CPU (rst_cpu), 2 = software restart (rst_sw), 3 = CPU. The field resets to 1.
- R9: The reset pulse lasts exactly one cycle and drives only one output. After the pulse, control bit 0 reads 0.
- R10: After reset all outputs are low and control reads 0x2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word select: 0 control, 1 lengths, 2 ping |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_pre | output | 1 | Sticky pretimeout interrupt |
| irq_expire | output | 1 | Sticky expiry interrupt |
| rst_chip | output | 1 | Whole-chip reset pulse |
| rst_cpu | output | 1 | CPU reset pulse |
| rst_sw | output | 1 | Software-restart pulse |

## Verification
The first sweep runs every phase-1 length from 1 to 32, each paired with a phase-2 length that brings the total to 33, and cycles the scope field through all four codes. This sweep separates an off-by-one in either length field from a mix-up between the two fields. A small grid of short length pairs then checks that the phase boundary falls exactly on a tick edge.

Three stimulus sequences land a ping or a disable at chosen points in the timeline:

- a ping one cycle before phase 1 would expire;
- a ping inside the grace period;
- a disable inside each phase.

These separate a ping that restarts phase 1 from one that wrongly touches phase 2, and a clean stop from a leaked pulse.

// File: rtl/wdog_twophase.sv
module wdog_twophase #(
  parameter int TICK_LOG2 = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_we,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_pre,
  output logic        irq_expire,
  output logic        rst_chip,
  output logic        rst_cpu,
  output logic        rst_sw
);
  localparam int LEN_W = 5;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_PH1 = 2'd1, ST_PH2 = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd0, A_LEN = 2'd1, A_PING = 2'd2;

  logic [1:0]           state;
  logic [TICK_LOG2-1:0] presc;
  logic [LEN_W-1:0]     tcnt, len1, len2;
  logic [1:0]           mode;
  logic [2:0]           rst_q;

  wire wr_ctrl  = bus_we && bus_addr == A_CTRL;
  wire wr_len   = bus_we && bus_addr == A_LEN;
  wire wr_ping  = bus_we && bus_addr == A_PING;
  wire running  = state != ST_IDLE;
  wire start    = wr_ctrl && bus_wdata[0] && !running;
  wire stop     = wr_ctrl && !bus_wdata[0];
  wire ping     = wr_ping && state == ST_PH1;
  wire tick     = &presc;
  wire [LEN_W-1:0] cur_len = (state == ST_PH2) ? len2 : len1;
  wire last     = running && tick && tcnt == cur_len;
  wire end1     = last && state == ST_PH1 && !stop && !ping;
  wire end2     = last && state == ST_PH2 && !stop;
  wire restart  = start || ping || !running;

  wire [2:0] scope = (mode == 2'd0) ? 3'b001 :
                     (mode == 2'd2) ? 3'b100 : 3'b010;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      tcnt  <= '0;
    end else if (restart) begin
      presc <= '0;
      tcnt  <= '0;
    end else begin
      presc <= presc + 1'b1;
      if (tick) tcnt <= (tcnt == cur_len) ? '0 : tcnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state <= ST_IDLE;
    else if (stop)  state <= ST_IDLE;
    else if (start) state <= ST_PH1;
    else if (end1)  state <= ST_PH2;
    else if (end2)  state <= ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 2'd1;
      len1 <= '1;
      len2 <= '1;
    end else begin
      if (wr_ctrl) mode <= bus_wdata[2:1];
      if (wr_len) begin
        len1 <= bus_wdata[LEN_W-1:0];
        len2 <= bus_wdata[8 +: LEN_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_pre    <= 1'b0;
      irq_expire <= 1'b0;
      rst_q      <= '0;
    end else begin
      irq_pre    <= end1 | (irq_pre & ~(wr_ctrl & bus_wdata[8]));
      irq_expire <= end2 | (irq_expire & ~(wr_ctrl & bus_wdata[9]));
      rst_q      <= end2 ? scope : 3'b000;
    end
  end

  assign {rst_sw, rst_cpu, rst_chip} = rst_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: begin
        bus_rdata[0]   = running;
        bus_rdata[2:1] = mode;
        bus_rdata[8]   = irq_pre;
        bus_rdata[9]   = irq_expire;
      end
      A_LEN: begin
        bus_rdata[LEN_W-1:0]  = len1;
        bus_rdata[8 +: LEN_W] = len2;
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_twophase_chk.sv
module wdog_twophase_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  state,
  input logic [2:0]  rst_vec,
  input logic        irq_expire,
  input logic        bus_we,
  input logic [1:0]  bus_addr,
  input logic [31:0] bus_wdata
);
  wire stop_wr = bus_we && bus_addr == 2'd0 && !bus_wdata[0];
  wire unused  = ^bus_wdata[31:1];

  a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rst_vec));
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_vec) |=> !(|rst_vec));
  a_r9_off_after: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_vec) |-> state == 2'd0);
  a_r6_irq_with_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (|rst_vec) |-> irq_expire);
  a_r4_reset_from_ph2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|rst_vec) |-> $past(state) == 2'd2);
  a_r1_ph2_follows_ph1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && $past(state) != 2'd2) |-> $past(state) == 2'd1);
  a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_wr && !unused) |=> (state == 2'd0 && !(|rst_vec)));
  a_r5_stop_any: assert property (@(posedge clk) disable iff (!rst_n)
    stop_wr |=> state == 2'd0);
endmodule

bind wdog_twophase wdog_twophase_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .rst_vec(rst_q),
  .irq_expire(irq_expire), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata)
);

// File: tb/sim_wdog_twophase.sv
module sim_wdog_twophase;
  localparam int CLK_P = 10;
  localparam int TL = 2;
  localparam int T = 1 << TL;
  localparam int NEVER = 1 << 30;

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [1:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq_pre, irq_expire, rst_chip, rst_cpu, rst_sw;
  int checks = 0, errors = 0, edge_cnt = 0, wr_edge = 0;
  bit done = 0;

  wdog_twophase #(.TICK_LOG2(TL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pre(irq_pre),
    .irq_expire(irq_expire), .rst_chip(rst_chip), .rst_cpu(rst_cpu),
    .rst_sw(rst_sw));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) edge_cnt <= edge_cnt + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at edge %0d", req, act, exp, edge_cnt);
    end
  endtask

  function automatic int scope(input int m);
    return (m == 0) ? 1 : (m == 2) ? 4 : 2;
  endfunction

  task automatic wr(input int a, input int d);
    bus_addr = a[1:0]; bus_wdata = d; bus_we = 1;
    @(posedge clk);
    #1;
    wr_edge = edge_cnt;
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
  endtask

  task automatic rd(input int a, input string req, input int exp);
    bus_addr = a[1:0];
    @(negedge clk);
    chk(req, int'(bus_rdata), exp);
    bus_addr = 0;
  endtask

  task automatic watch(input int e0, input int pre_at, input int exp_at,
                       input int m, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      begin
        int d = edge_cnt - e0;
        chk({req, " irq_pre"}, int'(irq_pre), int'(d >= pre_at));
        chk({req, " irq_expire"}, int'(irq_expire), int'(d >= exp_at));
        chk({req, " reset"}, int'({rst_sw, rst_cpu, rst_chip}),
            (d == exp_at) ? scope(m) : 0);
      end
    end
  endtask

  task automatic run(input int l1, input int l2, input int m, input string req);
    int e0;
    wr(1, ((l2 - 1) << 8) | (l1 - 1));
    wr(0, 32'h300 | (m << 1) | 1);
    e0 = wr_edge;
    watch(e0, l1 * T, (l1 + l2) * T, m, (l1 + l2) * T + 2 * T - 1, req);
    rd(0, "R9 enable cleared after reset", 32'h300 | (m << 1));
  endtask

  initial begin
    int e0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 outputs", int'({irq_pre, irq_expire, rst_chip, rst_cpu, rst_sw}), 0);
    rd(0, "R10 R8 control reset", 32'h2);
    rd(1, "R2 lengths reset", 32'h1F1F);
    rst_n = 1;
    @(negedge clk);
    wr(1, 32'h0A13);
    rd(1, "R2 lengths readback", 32'h0A13);
    // R1 R2 R8 sweep across all lengths and scopes
    for (int l1 = 1; l1 <= 32; l1++) run(l1, 33 - l1, l1 % 4, "R1 R2 R8 sweep");
    for (int a = 1; a <= 4; a++)
      for (int b = 1; b <= 4; b++) run(a, b, (a + b) % 3, "R1 R9 grid");
    // R3 ping just before phase 1 expiry
    wr(1, 32'h0102); wr(0, 32'h303); e0 = wr_edge;
    watch(e0, 3 * T, 5 * T, 1, 3 * T - 2, "R3 before ping");
    wr(2, 32'h0); e0 = wr_edge;
    watch(e0, 3 * T, 5 * T, 1, 6 * T, "R3 after ping");
    // R4 ping in phase 2 ignored
    wr(1, 32'h0200); wr(0, 32'h301); e0 = wr_edge;
    watch(e0, T, 4 * T, 0, T + 1, "R4 before ping");
    wr(2, 32'h1);
    watch(e0, T, 4 * T, 0, 3 * T + 2, "R4 after ping");
    // R7 write-one-to-clear, one flag at a time
    rd(0, "R7 both flags set", 32'h300);
    wr(0, 32'h100);
    @(negedge clk);
    chk("R7 irq_pre cleared", int'(irq_pre), 0);
    chk("R7 irq_expire kept", int'(irq_expire), 1);
    wr(0, 32'h200);
    @(negedge clk);
    chk("R7 irq_expire cleared", int'(irq_expire), 0);
    // R5 disable in phase 2
    wr(1, 32'h0100); wr(0, 32'h305); e0 = wr_edge;
    watch(e0, T, 3 * T, 2, T + 1, "R5 phase2 run");
    wr(0, 32'h4);
    watch(e0, T, NEVER, 2, 5 * T, "R5 phase2 stopped");
    rd(0, "R5 enable reads 0", 32'h104);
    // R5 disable in phase 1
    wr(1, 32'h0000); wr(0, 32'h303); e0 = wr_edge;
    watch(e0, 2 * T, 2 * T, 1, T, "R5 phase1 run");
    wr(0, 32'h302);
    watch(e0, NEVER, NEVER, 1, 4 * T, "R5 phase1 stopped");
    rd(0, "R5 enable reads 0 again", 32'h2);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule